// File: doc/BRIEF.md
# Flash Sector Protection Manager

This block keeps the protection state of a 64-Mbit serial flash array split into 128 sectors of 64 KB, and judges every program or erase request against it before the array is touched. Each sector carries a volatile protect bit and a permanent lockdown bit. Decoded command strobes set or clear one protect bit, set or clear all of them at once, or lock a sector down. An active-low write-protect input freezes every protect bit so that protected sectors stay protected.

A request gives an address and a kind: a page program, an erase of 4 KB, 32 KB or 64 KB, or a full-chip erase. One cycle later the block answers with allow or reject and updates a sticky failure flag that stays readable between requests. A status port returns the protect and lock state of any addressed sector. Lockdown bits model nonvolatile cells. They start cleared when the device is first loaded, and no later reset or command clears them.

Top module: `sector_guard`

## Requirements
- R1: The sector index is address bits 22 to 16. A pulse on `cmd_prot` sets the protect bit of the sector in `cmd_addr`, and a pulse on `cmd_unprot` clears it. Other sectors are unchanged.
- R2: A pulse on `cmd_gprot` sets every protect bit, and a pulse on `cmd_gunprot` clears every protect bit.
- R3: While `rst` is high, every protect bit is set, `resp_valid` and `fail_flag` are 0, and lockdown bits keep their values.
- R4: A pulse on `cmd_lock` locks the addressed sector, whatever the level of `wp_n`. No reset and no command clears a lock. A locked sector reports as protected.
- R5: While `wp_n` is 0, all four protect-bit commands are ignored.
- R6: `req_kind` uses this encoding: 0 = program, 1 = 4 KB erase, 2 = 32 KB erase, 3 = 64 KB erase, 4 = full-chip erase, 5 to 7 = reserved. Kinds 0 to 3 are allowed only if the 64 KB sector that holds `req_addr` is neither protected nor locked. Reserved kinds are always rejected.
- R7: A full-chip erase is allowed only if no sector is protected and no sector is locked.
- R8: A request sampled at a clock edge produces `resp_valid` = 1 in the next cycle, with exactly one of `resp_allow` and `resp_reject` high. The request is judged on the state from before any command strobed in the same cycle.
- R9: `fail_flag` goes to 1 with a rejection, goes to 0 with an acceptance, and holds its value in cycles with no response.
- R10: `stat_prot` and `stat_lock` show the protect state (protect bit OR lock) and the lock state of the sector in `stat_addr`, one cycle after the address is presented.
- R11: When several protect-bit strobes arrive in one cycle, the priority is global protect, then global unprotect, then single protect, then single unprotect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Write-protect; low freezes protect bits |
| cmd_prot | input | 1 | Protect one sector |
| cmd_unprot | input | 1 | Unprotect one sector |
| cmd_gprot | input | 1 | Protect all sectors |
| cmd_gunprot | input | 1 | Unprotect all sectors |
| cmd_lock | input | 1 | Lock one sector permanently |
| cmd_addr | input | 23 | Byte address for single-sector commands |
| req_valid | input | 1 | Program/erase request strobe |
| req_kind | input | 3 | Request kind (see R6) |
| req_addr | input | 23 | Request byte address |
| stat_addr | input | 23 | Byte address for the status read |
| resp_valid | output | 1 | Verdict present |
| resp_allow | output | 1 | Request accepted |
| resp_reject | output | 1 | Request refused |
| fail_flag | output | 1 | Sticky result of the last verdict |
| stat_prot | output | 1 | Addressed sector is protected or locked |
| stat_lock | output | 1 | Addressed sector is locked |

## Verification
The bench checks that a 4 KB or 32 KB erase is judged by the 64 KB sector that contains it. A design that ignored neighbouring sectors, or picked the wrong address bits, would pass or fail the wrong erases. It checks that a full-chip erase is refused when a single sector is guarded, even when that sector is only locked and not protected. It holds write-protect low and tries to unprotect, which a design that froze only some commands would allow. It also checks that a lock survives both a global unprotect and a reset, and that a request and a command in the same cycle are judged on the older state. A design that lost the lock would accept erases of a read-only sector, and one that looked ahead would refuse an erase it should accept.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [2:0] {
    RK_PROG  = 3'd0,
    RK_E4K   = 3'd1,
    RK_E32K  = 3'd2,
    RK_E64K  = 3'd3,
    RK_CHIP  = 3'd4
  } req_kind_t;
endpackage

// File: rtl/sg_prot_bank.sv
module sg_prot_bank #(
  parameter int SECTORS = 128,
  parameter int SEC_W   = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wp_n,
  input  logic               cmd_prot,
  input  logic               cmd_unprot,
  input  logic               cmd_gprot,
  input  logic               cmd_gunprot,
  input  logic               cmd_lock,
  input  logic [SEC_W-1:0]   cmd_sec,
  output logic [SECTORS-1:0] prot_vec,
  output logic [SECTORS-1:0] lock_vec
);
  // One protect flop and one lock flop per sector; global commands touch all.
  for (genvar g = 0; g < SECTORS; g++) begin : g_sec
    logic hit;
    logic prot_q;
    logic lock_q = 1'b0;  // models an erased nonvolatile cell at load time

    assign hit = (cmd_sec == SEC_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        prot_q <= 1'b1;
      end else if (wp_n) begin
        if (cmd_gprot)                prot_q <= 1'b1;
        else if (cmd_gunprot)         prot_q <= 1'b0;
        else if (cmd_prot && hit)     prot_q <= 1'b1;
        else if (cmd_unprot && hit)   prot_q <= 1'b0;
      end
    end

    // Lock is set-only and ignores reset.
    always_ff @(posedge clk) begin
      if (cmd_lock && hit) lock_q <= 1'b1;
    end

    assign prot_vec[g] = prot_q;
    assign lock_vec[g] = lock_q;
  end
endmodule

// File: rtl/sg_req_check.sv
module sg_req_check
  import sg_pkg::*;
#(
  parameter int SECTORS = 128,
  parameter int SEC_W   = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [2:0]         req_kind,
  input  logic [SEC_W-1:0]   req_sec,
  input  logic [SECTORS-1:0] prot_vec,
  input  logic [SECTORS-1:0] lock_vec,
  output logic               resp_valid,
  output logic               resp_allow,
  output logic               resp_reject,
  output logic               fail_flag
);
  logic [SECTORS-1:0] guard_vec;
  logic               any_guard;
  logic               ok;

  assign guard_vec = prot_vec | lock_vec;
  assign any_guard = |guard_vec;

  // Sub-sector erases and programs resolve to their containing 64 KB sector.
  always_comb begin
    case (req_kind)
      RK_PROG, RK_E4K, RK_E32K, RK_E64K: ok = ~guard_vec[req_sec];
      RK_CHIP:                           ok = ~any_guard;
      default:                           ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_allow  <= 1'b0;
      resp_reject <= 1'b0;
      fail_flag   <= 1'b0;
    end else begin
      resp_valid  <= req_valid;
      resp_allow  <= req_valid & ok;
      resp_reject <= req_valid & ~ok;
      if (req_valid) fail_flag <= ~ok;
    end
  end
endmodule

// File: rtl/sg_status_port.sv
module sg_status_port #(
  parameter int SECTORS = 128,
  parameter int SEC_W   = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEC_W-1:0]   stat_sec,
  input  logic [SECTORS-1:0] prot_vec,
  input  logic [SECTORS-1:0] lock_vec,
  output logic               stat_prot,
  output logic               stat_lock
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_prot <= 1'b0;
      stat_lock <= 1'b0;
    end else begin
      stat_prot <= prot_vec[stat_sec] | lock_vec[stat_sec];
      stat_lock <= lock_vec[stat_sec];
    end
  end
endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int SECTORS = 128,
  parameter int SEC_LSB = 16,
  parameter int ADDR_W  = SEC_LSB + $clog2(SECTORS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_n,
  input  logic              cmd_prot,
  input  logic              cmd_unprot,
  input  logic              cmd_gprot,
  input  logic              cmd_gunprot,
  input  logic              cmd_lock,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] stat_addr,
  output logic              resp_valid,
  output logic              resp_allow,
  output logic              resp_reject,
  output logic              fail_flag,
  output logic              stat_prot,
  output logic              stat_lock
);
  localparam int SEC_W = $clog2(SECTORS);

  logic [SEC_W-1:0]   cmd_sec, req_sec, stat_sec;
  logic [SECTORS-1:0] prot_vec, lock_vec;
  logic               unused_low;

  assign cmd_sec  = cmd_addr[SEC_LSB +: SEC_W];
  assign req_sec  = req_addr[SEC_LSB +: SEC_W];
  assign stat_sec = stat_addr[SEC_LSB +: SEC_W];
  assign unused_low = ^{cmd_addr[SEC_LSB-1:0], req_addr[SEC_LSB-1:0],
                        stat_addr[SEC_LSB-1:0]};

  sg_prot_bank #(.SECTORS(SECTORS), .SEC_W(SEC_W)) u_bank (
    .clk(clk), .rst(rst), .wp_n(wp_n),
    .cmd_prot(cmd_prot), .cmd_unprot(cmd_unprot),
    .cmd_gprot(cmd_gprot), .cmd_gunprot(cmd_gunprot),
    .cmd_lock(cmd_lock), .cmd_sec(cmd_sec),
    .prot_vec(prot_vec), .lock_vec(lock_vec)
  );

  sg_req_check #(.SECTORS(SECTORS), .SEC_W(SEC_W)) u_check (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_sec(req_sec), .prot_vec(prot_vec), .lock_vec(lock_vec),
    .resp_valid(resp_valid), .resp_allow(resp_allow),
    .resp_reject(resp_reject), .fail_flag(fail_flag)
  );

  sg_status_port #(.SECTORS(SECTORS), .SEC_W(SEC_W)) u_stat (
    .clk(clk), .rst(rst), .stat_sec(stat_sec),
    .prot_vec(prot_vec), .lock_vec(lock_vec),
    .stat_prot(stat_prot), .stat_lock(stat_lock)
  );
endmodule

// File: rtl/sg_guard_props.sv
module sg_guard_props
  import sg_pkg::*;
#(
  parameter int SECTORS = 128,
  parameter int SEC_W   = $clog2(SECTORS)
) (
  input logic               clk,
  input logic               rst,
  input logic               wp_n,
  input logic               req_valid,
  input logic [2:0]         req_kind,
  input logic [SEC_W-1:0]   req_sec,
  input logic [SECTORS-1:0] prot_vec,
  input logic [SECTORS-1:0] lock_vec,
  input logic               resp_valid,
  input logic               resp_allow,
  input logic               resp_reject,
  input logic               fail_flag
);
  // R4: a lock bit never falls
  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (($past(lock_vec) & ~lock_vec) == '0));

  // R5: write-protect low freezes the protect bits
  p_wp_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    !wp_n |=> $stable(prot_vec));

  // R7: full-chip erase refused when anything is guarded
  p_chip_guard_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == RK_CHIP && (|(prot_vec | lock_vec)))
      |=> (resp_valid && resp_reject));

  // R4: a locked sector refuses every request
  p_lock_reject_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && lock_vec[req_sec]) |=> resp_reject);

  // R8: verdict outputs are exclusive and only with resp_valid
  p_verdict_r8: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (resp_allow != resp_reject));
  p_no_stray_r8: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> !(resp_allow || resp_reject));

  // R9: failure flag tracks the verdict and holds between verdicts
  p_fail_track_r9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (fail_flag == resp_reject));
  p_fail_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> $stable(fail_flag));
endmodule

bind sector_guard sg_guard_props #(.SECTORS(SECTORS), .SEC_W(SEC_W)) u_props (
  .clk(clk), .rst(rst), .wp_n(wp_n), .req_valid(req_valid),
  .req_kind(req_kind), .req_sec(req_sec), .prot_vec(prot_vec),
  .lock_vec(lock_vec), .resp_valid(resp_valid), .resp_allow(resp_allow),
  .resp_reject(resp_reject), .fail_flag(fail_flag)
);

// File: tb/sim_sector_guard.sv
`timescale 1ns/1ps
module sim_sector_guard;
  localparam int NS = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp_n = 1'b1;
  logic cmd_prot = 0, cmd_unprot = 0, cmd_gprot = 0, cmd_gunprot = 0, cmd_lock = 0;
  logic [22:0] cmd_addr = '0, req_addr = '0, stat_addr = '0;
  logic req_valid = 0;
  logic [2:0] req_kind = '0;
  logic resp_valid, resp_allow, resp_reject, fail_flag, stat_prot, stat_lock;

  always #4 clk = ~clk;

  sector_guard u0 (
    .clk(clk), .rst(rst), .wp_n(wp_n),
    .cmd_prot(cmd_prot), .cmd_unprot(cmd_unprot), .cmd_gprot(cmd_gprot),
    .cmd_gunprot(cmd_gunprot), .cmd_lock(cmd_lock), .cmd_addr(cmd_addr),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .stat_addr(stat_addr), .resp_valid(resp_valid), .resp_allow(resp_allow),
    .resp_reject(resp_reject), .fail_flag(fail_flag),
    .stat_prot(stat_prot), .stat_lock(stat_lock)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit mprot [NS];
  bit mlock [NS];
  bit exp_q [$];
  string tag_q [$];

  // command mask bits: 0 prot, 1 unprot, 2 gprot, 3 gunprot, 4 lock
  localparam int C_P = 1, C_U = 2, C_GP = 4, C_GU = 8, C_L = 16;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit model_ok(input int kind, input int sec);
    bit any = 0;
    for (int i = 0; i < NS; i++) any |= mprot[i] | mlock[i];
    if (kind <= 3) return !(mprot[sec] | mlock[sec]);
    if (kind == 4) return !any;
    return 0;
  endfunction

  function automatic void model_cmd(input int m, input int sec);
    if (m & C_L) mlock[sec] = 1;
    if (wp_n) begin
      if (m & C_GP)      for (int i = 0; i < NS; i++) mprot[i] = 1;
      else if (m & C_GU) for (int i = 0; i < NS; i++) mprot[i] = 0;
      else if (m & C_P)  mprot[sec] = 1;
      else if (m & C_U)  mprot[sec] = 0;
    end
  endfunction

  function automatic logic [22:0] mk_addr(input int sec, input int low);
    return {7'(sec), 16'(low)};
  endfunction

  // Drives a command mask and, optionally, a request in the same cycle.
  task automatic drive(input int m, input int csec, input bit rq, input int kind,
                       input int rsec, input string tag);
    @(negedge clk);
    if (rq) begin
      exp_q.push_back(model_ok(kind, rsec));
      tag_q.push_back(tag);
      req_valid = 1; req_kind = 3'(kind); req_addr = mk_addr(rsec, 16'h7F3 + rsec);
    end
    cmd_prot = (m & C_P) != 0; cmd_unprot = (m & C_U) != 0;
    cmd_gprot = (m & C_GP) != 0; cmd_gunprot = (m & C_GU) != 0;
    cmd_lock = (m & C_L) != 0;
    cmd_addr = mk_addr(csec, 16'hA5C3);
    model_cmd(m, csec);
    @(negedge clk);
    req_valid = 0; cmd_prot = 0; cmd_unprot = 0; cmd_gprot = 0;
    cmd_gunprot = 0; cmd_lock = 0;
  endtask

  task automatic cmd(input int m, input int sec);
    drive(m, sec, 0, 0, 0, "");
  endtask

  task automatic req(input int kind, input int sec, input string tag);
    drive(0, 0, 1, kind, sec, tag);
  endtask

  task automatic stat(input int sec, input string tag);
    @(negedge clk);
    stat_addr = mk_addr(sec, 16'hFFFF);
    @(negedge clk);
    chk(stat_prot == (mprot[sec] | mlock[sec]), {tag, " stat_prot"},
        int'(stat_prot), int'(mprot[sec] | mlock[sec]));
    chk(stat_lock == mlock[sec], {tag, " stat_lock"}, int'(stat_lock), int'(mlock[sec]));
  endtask

  // Scoreboard monitor: pops one expected verdict per response.
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected response", 1, 0);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(resp_allow == e && resp_reject == !e, {t, " verdict R8"}, int'(resp_allow), int'(e));
        chk(fail_flag == !e, {t, " fail_flag R9"}, int'(fail_flag), int'(!e));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1;
    for (int i = 0; i < NS; i++) mprot[i] = 1;
    repeat (3) @(negedge clk);
    chk(resp_valid == 0, "R3 resp_valid in reset", int'(resp_valid), 0);
    chk(fail_flag == 0, "R3 fail_flag in reset", int'(fail_flag), 0);
    rst = 0;
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin mprot[i] = 1; mlock[i] = 0; end
    repeat (3) @(negedge clk);
    do_reset();
    stat(5, "R3 R10 reset state");
    req(0, 5, "R6 program protected");
    repeat (3) @(negedge clk);
    chk(fail_flag == 1, "R9 fail held idle", int'(fail_flag), 1);
    cmd(C_GU, 0);
    stat(100, "R2 global unprotect");
    req(3, 100, "R6 64K erase open");
    cmd(C_P, 7);
    stat(7, "R1 single protect");
    stat(6, "R1 neighbour untouched");
    req(1, 7, "R6 4K erase in protected");
    req(1, 6, "R6 4K erase neighbour");
    req(2, 8, "R6 32K erase open");
    cmd(C_U, 7);
    req(2, 7, "R1 32K after unprotect");
    req(4, 0, "R7 chip erase clear");
    cmd(C_P, 127);
    req(4, 0, "R7 chip erase one guarded");
    cmd(C_U, 127);
    cmd(C_P, 40);
    @(negedge clk); wp_n = 0;
    cmd(C_U, 40);
    stat(40, "R5 unprotect ignored");
    cmd(C_GU, 0);
    stat(40, "R5 global unprotect ignored");
    cmd(C_GP, 0);
    stat(3, "R5 global protect ignored");
    cmd(C_L, 60);
    stat(60, "R4 lock with wp low");
    @(negedge clk); wp_n = 1;
    cmd(C_GU, 0);
    stat(60, "R4 lock survives global unprotect");
    req(1, 60, "R4 erase locked sector");
    req(4, 0, "R7 chip erase lock only");
    req(5, 9, "R6 reserved kind");
    cmd(C_GP | C_U, 9);
    stat(9, "R11 gprot over unprot");
    cmd(C_GU | C_P, 11);
    stat(11, "R11 gunprot over prot");
    drive(C_P, 12, 1, 3, 12, "R8 same-cycle old state");
    stat(12, "R8 command applied after");
    do_reset();
    stat(60, "R3 R4 lock kept over reset");
    stat(61, "R3 protect after reset");
    req(0, 61, "R6 program after reset");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 missing responses", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule